// File: doc/BRIEF.md
# I2C Register-Access Target with 16-bit Pointer

This block is an I2C target that lets a bus host reach a control-register space through a 16-bit register pointer. The block runs on a system clock that is at least eight times the SCL rate. It samples SCL and SDA through synchronizers and finds SCL edges and start and stop conditions from the sampled lines. It pulls SDA low through a single output-enable, so it never drives the line high. A simple synchronous register port carries the pointer, the write data, a one-cycle write strobe and the returned read data.

A write transfer carries the device address with the direction bit at 0, then the pointer high byte, then the pointer low byte, then any number of data bytes. The block writes each data byte to the register the pointer names and then increments the pointer. A read transfer carries the device address with the direction bit at 1 and has no pointer phase. The block sends data starting at the current pointer, so a host sets the pointer in a write transfer and then reads, either after a stop or after a repeated start. A start or a stop can arrive at any point. Either one abandons the byte being shifted.

The controller has these states: `ST_IDLE`, `ST_RX_ADDR` (address byte), `ST_ACK_ADDR`, `ST_RX_PHI` / `ST_ACK_PHI` (pointer high byte), `ST_RX_PLO` / `ST_ACK_PLO` (pointer low byte), `ST_RX_DATA` / `ST_ACK_DATA` (write data), `ST_TX_DATA` (read data) and `ST_MACK` (host acknowledge). A stop sends any state to `ST_IDLE`. A start sends any state to `ST_RX_ADDR`.

The remaining transitions all happen on an SCL falling edge:
- `ST_RX_ADDR` moves to `ST_ACK_ADDR` on an address match, and to `ST_IDLE` on a mismatch.
- `ST_ACK_ADDR` moves to `ST_TX_DATA` for a read, or to `ST_RX_PHI` for a write.
- The write path runs `ST_RX_PHI` → `ST_ACK_PHI` → `ST_RX_PLO` → `ST_ACK_PLO` → `ST_RX_DATA`, then loops `ST_RX_DATA` ↔ `ST_ACK_DATA`.
- `ST_TX_DATA` moves to `ST_MACK` after the eighth bit.
- `ST_MACK` returns to `ST_TX_DATA` when the host acknowledges, and goes to `ST_IDLE` when it does not.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, sda_oe is 0, reg_we is 0 and reg_addr is 0x0000.
- R2: The first byte after a start is a 7-bit device address, MSB first, followed by a direction bit (0 = write, 1 = read). The block pulls SDA low during the ninth SCL clock only when the address equals DEV_ADDR.
- R3: After a non-matching address, the block leaves SDA released and issues no write strobe until the next start.
- R4: In a write transfer, the two bytes after the address set the pointer, high byte first. Each later byte is acknowledged and is presented once on reg_wdata, with reg_we high and reg_addr equal to the pointer. The number of bytes is unlimited.
- R5: The pointer increments by one after each data byte, written or read, and wraps from 0xFFFF to 0x0000.
- R6: A read transfer sends bytes MSB first, starting at the current pointer, with no pointer phase. The block releases SDA in the ninth clock. The pointer keeps its value across transfers.
- R7: When the host does not acknowledge a read byte, the block stops driving SDA until the next start.
- R8: A start or a stop at any point discards a partially received byte. A repeated start behaves as a stop followed by a start.
- R9: sda_oe changes only while SCL is low.
- R10: reg_we is high for exactly one system-clock cycle per written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 16 | Register pointer |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
The bench builds the block with its defaults: DEV_ADDR = 0x2A, 8-bit bytes and two synchronizer stages. An 8-bit byte gives a 7-bit address space, small enough to try every one of the 128 addresses and confirm that only one is acknowledged. A 16-bit pointer lets a write that starts near 0xFFFE cross the wrap point within a few bytes. The register file in the bench is indexed by the low pointer byte and preloaded with an arithmetic pattern, so every read value is known in advance.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_PHI,
        ST_ACK_PHI,
        ST_RX_PLO,
        ST_ACK_PLO,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_TX_DATA,
        ST_MACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES synchronizer flops plus one history flop per line
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;
    logic            scl_p;
    logic            sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_p     = scl_sh[STAGES];
    assign sda_p     = sda_sh[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_hi,
    input  logic            load_lo,
    input  logic            inc,
    input  logic [BW-1:0]   din,
    output logic [2*BW-1:0] ptr
);
    localparam int AW = 2 * BW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (load_hi) ptr[AW-1:BW] <= din;
        else if (load_lo) ptr[BW-1:0] <= din;
        else if (inc)     ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         BW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [BW-1:0] rdata,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [BW-1:0] wdata,
    output logic          ld_hi,
    output logic          ld_lo,
    output logic          ptr_inc
);
    localparam int CW = $clog2(BW + 1);

    tgt_state_e    state, nxt;
    logic [BW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic          nack_q;
    logic          done;
    logic          rx_st;
    logic          rd_go;
    logic          rd_more;

    assign done    = (cnt == CW'(BW));
    assign rx_st   = (state == ST_RX_ADDR) || (state == ST_RX_PHI) ||
                     (state == ST_RX_PLO)  || (state == ST_RX_DATA);
    assign rd_go   = (state == ST_ACK_ADDR) && scl_fall && shreg[0];
    assign rd_more = (state == ST_MACK) && scl_fall && !nack_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_RX_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_RX_ADDR:  if (scl_fall && done)
                                 nxt = (shreg[BW-1:1] == DEV_ADDR) ? ST_ACK_ADDR : ST_IDLE;
                ST_ACK_ADDR: if (scl_fall) nxt = shreg[0] ? ST_TX_DATA : ST_RX_PHI;
                ST_RX_PHI:   if (scl_fall && done) nxt = ST_ACK_PHI;
                ST_ACK_PHI:  if (scl_fall) nxt = ST_RX_PLO;
                ST_RX_PLO:   if (scl_fall && done) nxt = ST_ACK_PLO;
                ST_ACK_PLO:  if (scl_fall) nxt = ST_RX_DATA;
                ST_RX_DATA:  if (scl_fall && done) nxt = ST_ACK_DATA;
                ST_ACK_DATA: if (scl_fall) nxt = ST_RX_DATA;
                ST_TX_DATA:  if (scl_fall && cnt == CW'(BW - 1)) nxt = ST_MACK;
                ST_MACK:     if (scl_fall) nxt = nack_q ? ST_IDLE : ST_TX_DATA;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // shift register, bit counter, host acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            nack_q <= 1'b1;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else if (rx_st) begin
            if (scl_rise && !done) begin
                shreg <= {shreg[BW-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end else if (scl_fall && done) begin
                cnt <= '0;
            end
        end else if (rd_go || rd_more) begin
            shreg <= rdata;
            cnt   <= '0;
        end else if (state == ST_TX_DATA && scl_fall) begin
            shreg <= {shreg[BW-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
        end else if (state == ST_MACK && scl_rise) begin
            nack_q <= sda_s;
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state == ST_ACK_ADDR) || (state == ST_ACK_PHI) ||
                  (state == ST_ACK_PLO)  || (state == ST_ACK_DATA) ||
                  ((state == ST_TX_DATA) && !shreg[BW-1]);
        wr_stb  = (state == ST_RX_DATA) && scl_fall && done;
        ld_hi   = (state == ST_RX_PHI) && scl_fall && done;
        ld_lo   = (state == ST_RX_PLO) && scl_fall && done;
        ptr_inc = wr_stb || rd_go || rd_more;
        wdata   = shreg;
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         BYTE_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [2*BYTE_W-1:0]   reg_addr,
    output logic [BYTE_W-1:0]     reg_wdata,
    output logic                  reg_we,
    input  logic [BYTE_W-1:0]     reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ld_hi, ld_lo, ptr_inc;

    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR), .BW(BYTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rdata(reg_rdata), .sda_oe(sda_oe), .wr_stb(reg_we), .wdata(reg_wdata),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .ptr_inc(ptr_inc)
    );

    i2c_tgt_ptr #(.BW(BYTE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_hi(ld_hi), .load_lo(ld_lo),
        .inc(ptr_inc), .din(reg_wdata), .ptr(reg_addr)
    );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          stop_det,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr
);
    // R9
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R10
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == $past(reg_addr) + 1'b1);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4
    we_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_s);
endmodule

bind i2c_reg_target i2c_tgt_chk #(.AW(2 * BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
    localparam logic [6:0] DEV = 7'h2A;
    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic [7:0]  reg_rdata;
    logic        sda_line;

    logic [7:0]  mem [0:255];
    int          wcnt = 0;
    logic [15:0] last_a;
    logic [7:0]  last_d;
    int          oe_hits = 0;
    int          r9_viol = 0;
    int          r10_viol = 0;
    logic        oe_prev = 1'b0;
    logic        we_prev = 1'b0;
    int          vecs = 0;
    int          errs = 0;

    always #4 clk = ~clk;

    assign sda_line  = ~(m_low | sda_oe);
    assign reg_rdata = mem[reg_addr[7:0]];

    i2c_reg_target #(.DEV_ADDR(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h96;

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr[7:0]] <= reg_wdata;
            last_a <= reg_addr;
            last_d <= reg_wdata;
            wcnt   <= wcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (sda_oe) oe_hits++;
        if (sda_oe !== oe_prev && scl) r9_viol++;
        if (reg_we && we_prev) r10_viol++;
        oe_prev = sda_oe;
        we_prev = reg_we;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(2 * Q);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; tick(Q);
            scl = 1'b1;    tick(2 * Q);
            scl = 1'b0;    tick(Q);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        put_bits(b, 8);
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic get_byte(output logic [7:0] b, input logic give_ack);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl = 1'b0;
        end
        m_low = give_ack; tick(Q);
        scl = 1'b1;       tick(2 * Q);
        scl = 1'b0;       tick(Q);
        m_low = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        logic a;
        put_byte({DEV, 1'b0}, a);
        put_byte(p[15:8], a);
        put_byte(p[7:0], a);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errs++;
        $display("FAIL watchdog (all requirements) act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        int         w0;
        int         h0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(reg_we == 1'b0, "R1 reg_we", int'(reg_we), 0);
        chk(reg_addr == 16'h0, "R1 reg_addr", int'(reg_addr), 0);

        // R2 / R3: every 7-bit address, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({a[6:0], 1'b0}, ack);
            chk(ack == (a[6:0] == DEV), "R2 address ack", int'(ack), int'(a[6:0] == DEV));
            if (a[6:0] != DEV) begin
                w0 = wcnt;
                put_byte(8'h00, ack);
                chk(!ack && wcnt == w0, "R3 idle after mismatch", int'(ack), 0);
            end
            bus_stop();
        end

        // R4 / R5: write across the pointer wrap
        bus_start();
        set_ptr(16'hFFFE);
        for (int k = 0; k < 4; k++) begin
            w0 = wcnt;
            put_byte(8'(k * 59 + 5), ack);
            chk(ack, "R4 data ack", int'(ack), 1);
            chk(wcnt == w0 + 1, "R10 one strobe", wcnt - w0, 1);
            chk(last_a == 16'(32'hFFFE + k), "R5 write address", int'(last_a), int'(16'(32'hFFFE + k)));
            chk(last_d == 8'(k * 59 + 5), "R4 write data", int'(last_d), int'(8'(k * 59 + 5)));
        end
        bus_stop();
        chk(reg_addr == 16'h0002, "R5 wrap", int'(reg_addr), 2);

        // R6 / R7: read back from 0xFFFE
        bus_start(); set_ptr(16'hFFFE); bus_stop();
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R2 read ack", int'(ack), 1);
        for (int k = 0; k < 4; k++) begin
            get_byte(b, k != 3);
            chk(b == 8'(k * 59 + 5), "R6 read data", int'(b), int'(8'(k * 59 + 5)));
        end
        h0 = oe_hits;
        get_byte(b, 1'b0);
        chk(oe_hits == h0 && b == 8'hFF, "R7 released after nack", oe_hits - h0, 0);
        bus_stop();
        chk(reg_addr == 16'h0002, "R6 pointer after read", int'(reg_addr), 2);

        // R6: read with no pointer phase continues at the kept pointer
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        get_byte(b, 1'b0);
        chk(b == (8'h02 ^ 8'h96), "R6 kept pointer", int'(b), int'(8'h02 ^ 8'h96));
        bus_stop();
        chk(reg_addr == 16'h0003, "R6 pointer step", int'(reg_addr), 3);

        // R4 long write, R8 repeated-start read back
        bus_start();
        set_ptr(16'h0040);
        for (int k = 0; k < 16; k++) begin
            put_byte(8'(k * 17) ^ 8'h3C, ack);
            chk(ack, "R4 long write ack", int'(ack), 1);
        end
        bus_stop();
        bus_start();
        set_ptr(16'h0040);
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R8 repeated start ack", int'(ack), 1);
        for (int k = 0; k < 16; k++) begin
            get_byte(b, k != 15);
            chk(b == (8'(k * 17) ^ 8'h3C), "R8 read after repeated start", int'(b),
                int'(8'(k * 17) ^ 8'h3C));
        end
        bus_stop();

        // R8: partial byte then stop is discarded
        w0 = wcnt;
        bus_start();
        set_ptr(16'h0010);
        put_bits(8'hC3, 4);
        bus_stop();
        chk(wcnt == w0, "R8 partial byte dropped", wcnt - w0, 0);
        chk(reg_addr == 16'h0010, "R8 pointer kept", int'(reg_addr), 16);
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        get_byte(b, 1'b0);
        bus_stop();
        chk(b == (8'h10 ^ 8'h96), "R8 register untouched", int'(b), int'(8'h10 ^ 8'h96));

        // R8: start in the middle of an address byte
        bus_start();
        put_bits({DEV, 1'b0}, 3);
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        chk(ack, "R8 restart mid-byte", int'(ack), 1);
        bus_stop();

        chk(r9_viol == 0, "R9 sda_oe changes with SCL low", r9_viol, 0);
        chk(r10_viol == 0, "R10 single-cycle strobe", r10_viol, 0);
        finish_run();
    end
endmodule